// File: doc/BRIEF.md
# Two-Level Indirect Branch Target Predictor

This block supplies predicted targets for indirect branches from two tables. The first is a direct-mapped target array, indexed by the branch address and tagged with its upper bits. It holds every branch the core has resolved, together with a flag that marks the branch as indirect. The second is a history-indexed table. Each of its entries is addressed by the low address bits XOR'ed with the global history vector, and a partial tag confirms the hit. A branch gets an entry there only after the target array has given a wrong target for it while it was marked indirect.

A lookup is combinational. It presents the branch address and the current history, and it returns a valid flag, a target and a flag that tells which table supplied the target. The history table wins only when the target array hits with the indirect mark set and the history table also hits. Branch resolution comes in through a one-cycle strobe that carries the address, the history seen at prediction time, the real target, an indirect flag and a mispredict flag. The tables take the change on the next clock edge. The history vector comes from outside the block, and so does the direction prediction of conditional branches.

Top module: `itp_top`

## Requirements
- R1: After synchronous reset every entry of both tables is empty, so no lookup reports pred_valid until a resolve has filled an entry.
- R2: A resolve whose address misses the target array writes that address into the array (target-array index = address bits [3:0], tag = address bits [15:4]) with the resolved target and indirect flag. A lookup of that address then returns pred_valid=1 with that target, whether or not rs_mispredict was set.
- R3: Filling a new branch into the target array leaves the history table untouched. A lookup of the fresh branch under any history returns pred_from_hist=0.
- R4: A mispredicting resolve that hits a target-array entry marked indirect writes the history-table entry for that address and history (index = address[3:0] XOR history[3:0], tag = address[9:4] XOR {2'b00, history[7:4]}). It leaves the target array as it was. A later lookup with the same address and history returns that target with pred_from_hist=1. The same address under another history index still gets the array's target.
- R5: A history-table hit never makes a prediction on its own. If the target array misses, pred_valid=0. If the array hits without the indirect mark, the array's target is returned with pred_from_hist=0.
- R6: A resolve with rs_mispredict=0 that hits the target array changes neither table.
- R7: A mispredicting resolve for an indirect branch whose history entry already exists overwrites that entry's target in place.
- R8: A mispredicting resolve that hits a target-array entry not marked indirect rewrites that entry's target and its indirect flag from the resolve.
- R9: A table write becomes visible to lookups one clock edge after the strobe. A lookup in the same cycle as the resolve sees the old contents.
- R10: A target-array entry is a hit only if its tag matches. A branch that shares the index but has other upper bits misses, and when it is filled it displaces the older branch.
- R11: A history-table entry whose partial tag differs from the lookup's is ignored, and the target array's target is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 16 | Address of the branch being predicted |
| lk_hist | input | 8 | Global history at prediction time |
| pred_valid | output | 1 | The target array holds this branch |
| pred_target | output | 16 | Predicted target |
| pred_from_hist | output | 1 | Target came from the history table |
| rs_valid | input | 1 | Resolve strobe, one cycle per resolved branch |
| rs_pc | input | 16 | Address of the resolved branch |
| rs_hist | input | 8 | History that was used to predict it |
| rs_target | input | 16 | Actual target |
| rs_indirect | input | 1 | Resolved branch is indirect |
| rs_mispredict | input | 1 | Prediction was wrong |

## Verification
A lookup and a resolve can land in the same cycle on the same entry. The bench provokes this by raising the resolve strobe for a new address while it presents the same address on the lookup port. It checks for a miss before the edge and for the filled target just after it. History-table aliasing is also provoked on purpose. A second address whose index and partial tag equal those of an existing history entry is predicted first while it is not indirect, and the bench checks that the entry is ignored. After a fix marks that address indirect, the bench checks that the shared entry is now used.

// File: rtl/itp_pkg.sv
package itp_pkg;
    localparam int PC_W     = 16;
    localparam int HIST_W   = 8;
    localparam int TA_IDX_W = 4;
    localparam int HT_IDX_W = 4;
    localparam int HT_TAG_W = 6;
    localparam int TA_TAG_W = PC_W - TA_IDX_W;
    localparam int TA_N     = 1 << TA_IDX_W;
    localparam int HT_N     = 1 << HT_IDX_W;

    typedef logic [PC_W-1:0]     addr_t;
    typedef logic [HIST_W-1:0]   hist_t;
    typedef logic [TA_IDX_W-1:0] ta_idx_t;
    typedef logic [TA_TAG_W-1:0] ta_tag_t;
    typedef logic [HT_IDX_W-1:0] ht_idx_t;
    typedef logic [HT_TAG_W-1:0] ht_tag_t;

    typedef struct packed {
        logic    ind;
        ta_tag_t tag;
        addr_t   tgt;
    } ta_ent_t;

    typedef struct packed {
        ht_tag_t tag;
        addr_t   tgt;
    } ht_ent_t;

    typedef enum logic [1:0] {
        UPD_NONE,
        UPD_TA_FILL,
        UPD_TA_FIX,
        UPD_HT_WRITE
    } upd_e;

    function automatic ta_idx_t ta_index(input addr_t pc);
        return ta_idx_t'(pc);
    endfunction

    function automatic ta_tag_t ta_tagof(input addr_t pc);
        return ta_tag_t'(pc >> TA_IDX_W);
    endfunction

    function automatic ht_idx_t ht_index(input addr_t pc, input hist_t h);
        return ht_idx_t'(pc) ^ ht_idx_t'(h);
    endfunction

    function automatic ht_tag_t ht_tagof(input addr_t pc, input hist_t h);
        return ht_tag_t'(pc >> HT_IDX_W) ^ ht_tag_t'(h >> HT_IDX_W);
    endfunction
endpackage

// File: rtl/itp_target_array.sv
module itp_target_array
    import itp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  addr_t   lk_pc,
    output logic    lk_hit,
    output ta_ent_t lk_ent,
    input  addr_t   rd_pc,
    output logic    rd_hit,
    output ta_ent_t rd_ent,
    input  logic    we,
    input  addr_t   w_pc,
    input  logic    w_ind,
    input  addr_t   w_tgt
);
    logic [TA_N-1:0] vld;
    ta_ent_t         mem [TA_N];
    ta_idx_t         widx;

    assign widx   = ta_index(w_pc);
    assign lk_ent = mem[ta_index(lk_pc)];
    assign rd_ent = mem[ta_index(rd_pc)];
    assign lk_hit = vld[ta_index(lk_pc)] && (lk_ent.tag == ta_tagof(lk_pc));
    assign rd_hit = vld[ta_index(rd_pc)] && (rd_ent.tag == ta_tagof(rd_pc));

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else if (we) begin
            vld[widx] <= 1'b1;
            mem[widx] <= '{ind: w_ind, tag: ta_tagof(w_pc), tgt: w_tgt};
        end
    end

    // Without a write the valid set does not move
    assert_ta_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(we)) |-> $stable(vld));

    // A write is in place on the following edge
    assert_ta_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we)) |->
            (vld[$past(widx)] && mem[$past(widx)].tgt == $past(w_tgt)));
endmodule

// File: rtl/itp_hist_table.sv
module itp_hist_table
    import itp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t lk_pc,
    input  hist_t lk_hist,
    output logic  lk_hit,
    output addr_t lk_tgt,
    input  logic  we,
    input  addr_t w_pc,
    input  hist_t w_hist,
    input  addr_t w_tgt
);
    logic [HT_N-1:0] vld;
    ht_ent_t         mem [HT_N];
    ht_idx_t         ridx;
    ht_idx_t         widx;

    assign ridx   = ht_index(lk_pc, lk_hist);
    assign widx   = ht_index(w_pc, w_hist);
    assign lk_hit = vld[ridx] && (mem[ridx].tag == ht_tagof(lk_pc, lk_hist));
    assign lk_tgt = mem[ridx].tgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else if (we) begin
            vld[widx] <= 1'b1;
            mem[widx] <= '{tag: ht_tagof(w_pc, w_hist), tgt: w_tgt};
        end
    end

    // Allocation and in-place overwrite both land one edge later
    assert_ht_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we)) |->
            (vld[$past(widx)] && mem[$past(widx)].tgt == $past(w_tgt)));

    // The history table only changes when told to
    assert_ht_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(we)) |-> $stable(vld));
endmodule

// File: rtl/itp_top.sv
module itp_top
    import itp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [HIST_W-1:0] lk_hist,
    output logic              pred_valid,
    output logic [PC_W-1:0]   pred_target,
    output logic              pred_from_hist,
    input  logic              rs_valid,
    input  logic [PC_W-1:0]   rs_pc,
    input  logic [HIST_W-1:0] rs_hist,
    input  logic [PC_W-1:0]   rs_target,
    input  logic              rs_indirect,
    input  logic              rs_mispredict
);
    logic    ta_lk_hit, ta_rd_hit, ht_lk_hit;
    ta_ent_t ta_lk_ent, ta_rd_ent;
    addr_t   ht_lk_tgt;
    upd_e    upd;
    logic    ta_we, ht_we;

    itp_target_array u_ta (
        .clk    (clk),
        .rst    (rst),
        .lk_pc  (lk_pc),
        .lk_hit (ta_lk_hit),
        .lk_ent (ta_lk_ent),
        .rd_pc  (rs_pc),
        .rd_hit (ta_rd_hit),
        .rd_ent (ta_rd_ent),
        .we     (ta_we),
        .w_pc   (rs_pc),
        .w_ind  (rs_indirect),
        .w_tgt  (rs_target)
    );

    itp_hist_table u_ht (
        .clk     (clk),
        .rst     (rst),
        .lk_pc   (lk_pc),
        .lk_hist (lk_hist),
        .lk_hit  (ht_lk_hit),
        .lk_tgt  (ht_lk_tgt),
        .we      (ht_we),
        .w_pc    (rs_pc),
        .w_hist  (rs_hist),
        .w_tgt   (rs_target)
    );

    // Resolve decision: fill unknown branches into the array only; after a
    // wrong array target on an indirect branch, go to the history table.
    always_comb begin
        upd = UPD_NONE;
        if (rs_valid) begin
            if (!ta_rd_hit)
                upd = UPD_TA_FILL;
            else if (rs_mispredict)
                upd = ta_rd_ent.ind ? UPD_HT_WRITE : UPD_TA_FIX;
        end
    end

    assign ta_we = (upd == UPD_TA_FILL) || (upd == UPD_TA_FIX);
    assign ht_we = (upd == UPD_HT_WRITE);

    // Lookup: history table only behind an indirect-marked array hit
    always_comb begin
        pred_valid     = ta_lk_hit;
        pred_from_hist = ta_lk_hit && ta_lk_ent.ind && ht_lk_hit;
        pred_target    = pred_from_hist ? ht_lk_tgt : ta_lk_ent.tgt;
    end

    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred_valid);

    assert_fill_visible_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rs_valid && !ta_rd_hit && !rs_indirect)
         && lk_pc == $past(rs_pc)) |->
            (pred_valid && !pred_from_hist && pred_target == $past(rs_target)));
endmodule

// File: tb/itp_top_bench.sv
module itp_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] lk_pc;
    logic [7:0]  lk_hist;
    logic        pred_valid;
    logic [15:0] pred_target;
    logic        pred_from_hist;
    logic        rs_valid;
    logic [15:0] rs_pc;
    logic [7:0]  rs_hist;
    logic [15:0] rs_target;
    logic        rs_indirect;
    logic        rs_mispredict;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    itp_top u_itp_top (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hist(lk_hist),
        .pred_valid(pred_valid), .pred_target(pred_target),
        .pred_from_hist(pred_from_hist), .rs_valid(rs_valid), .rs_pc(rs_pc),
        .rs_hist(rs_hist), .rs_target(rs_target), .rs_indirect(rs_indirect),
        .rs_mispredict(rs_mispredict)
    );

    typedef struct packed {
        logic        rs;
        logic [15:0] pc;
        logic [7:0]  hist;
        logic [15:0] tgt;
        logic        ind;
        logic        misp;
        logic        ev;
        logic        es;
        logic [15:0] et;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    // A=1230 hA=5A -> hist idx A, tag 26. B=1231 hB=5B aliases it. C=5230 shares A's array slot.
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h1230, 8'h5A, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd1},  // R1 empty
        '{1'b1, 16'h1230, 8'h5A, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd2},  // R2 fill
        '{1'b0, 16'h1230, 8'h5A, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h4000, 8'd2},  // R2
        '{1'b0, 16'h1230, 8'hC3, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h4000, 8'd3},  // R3
        '{1'b1, 16'h1230, 8'h5A, 16'h4100, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd6},  // R6 correct
        '{1'b0, 16'h1230, 8'h5A, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h4000, 8'd6},  // R6
        '{1'b1, 16'h1230, 8'h5A, 16'h4200, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd4},  // R4 alloc
        '{1'b0, 16'h1230, 8'h5A, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h4200, 8'd4},  // R4
        '{1'b0, 16'h1230, 8'h5B, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h4000, 8'd4},  // R4 other idx
        '{1'b0, 16'h1230, 8'h7A, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h4000, 8'd11}, // R11 tag miss
        '{1'b1, 16'h1230, 8'h5A, 16'h4300, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd7},  // R7 overwrite
        '{1'b0, 16'h1230, 8'h5A, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h4300, 8'd7},  // R7
        '{1'b1, 16'h1231, 8'h5B, 16'h5000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd2},  // R2 fill B
        '{1'b0, 16'h1231, 8'h5B, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h5000, 8'd5},  // R5 alias ignored
        '{1'b1, 16'h1231, 8'h5B, 16'h5100, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd8},  // R8 fix
        '{1'b0, 16'h1231, 8'h5B, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h4300, 8'd8},  // R8 flag now set
        '{1'b0, 16'h1231, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h5100, 8'd8},  // R8 new target
        '{1'b0, 16'h5230, 8'h5A, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd10}, // R10 tag miss
        '{1'b1, 16'h5230, 8'h5A, 16'h6000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd10}, // R10 displace
        '{1'b0, 16'h1230, 8'h5A, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd10}, // R10 A gone
        '{1'b0, 16'h5230, 8'h5A, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h6000, 8'd5}   // R5 hist hit ignored
    };

    task automatic check(input int req, input logic ev, input logic es, input logic [15:0] et);
        checks++;
        if (pred_valid !== ev || (ev && (pred_from_hist !== es || pred_target !== et))) begin
            failures++;
            $display("FAIL R%0d: got valid=%0b hist=%0b tgt=%h, want valid=%0b hist=%0b tgt=%h",
                     req, pred_valid, pred_from_hist, pred_target, ev, es, et);
        end
    endtask

    task automatic resolve(input logic [15:0] pc, input logic [7:0] h, input logic [15:0] t,
                           input logic ind, input logic misp);
        rs_pc = pc; rs_hist = h; rs_target = t; rs_indirect = ind; rs_mispredict = misp;
        rs_valid = 1'b1;
        @(negedge clk);
        rs_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rs_valid = 1'b0; rs_pc = '0; rs_hist = '0; rs_target = '0;
        rs_indirect = 1'b0; rs_mispredict = 1'b0; lk_pc = '0; lk_hist = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rs) begin
                resolve(VEC[i].pc, VEC[i].hist, VEC[i].tgt, VEC[i].ind, VEC[i].misp);
            end else begin
                lk_pc = VEC[i].pc; lk_hist = VEC[i].hist;
                #1;
                check(int'(VEC[i].req), VEC[i].ev, VEC[i].es, VEC[i].et);
                @(negedge clk);
            end
        end

        // R9: same-cycle lookup sees old contents, new contents after one edge
        lk_pc = 16'h7774; lk_hist = 8'h00;
        rs_pc = 16'h7774; rs_hist = 8'h00; rs_target = 16'h9000;
        rs_indirect = 1'b0; rs_mispredict = 1'b1; rs_valid = 1'b1;
        #1;
        check(9, 1'b0, 1'b0, 16'h0000);
        @(negedge clk);
        rs_valid = 1'b0;
        #1;
        check(9, 1'b1, 1'b0, 16'h9000);
        @(negedge clk);

        // R1: reset in mid-run empties both tables
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lk_pc = 16'h5230; lk_hist = 8'h5A;
        #1;
        check(1, 1'b0, 1'b0, 16'h0000);
        lk_pc = 16'h1231; lk_hist = 8'h5B;
        #1;
        check(1, 1'b0, 1'b0, 16'h0000);
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule